// File: doc/BRIEF.md
# Refresh Request Queue and Row-Addressed Refresh Dispatcher

This block sits in a DRAM controller between the per-row timeout tracker and the DRAM command pins. Each time the tracker finds a row whose timeout has run out, it pushes that row's bank and row address into a small FIFO. The dispatcher takes entries oldest first. For each one it runs a row-addressed refresh cycle: the row address goes on the address bus, the bank goes on the bank select, and RAS is held low for a parameterized number of controller clocks. CAS and WE stay high for that whole time. If the target bank still has a page open, the dispatcher first issues a precharge to that bank, which writes the page back, and then waits a recovery time before the refresh strobe.

The command pins are shared with the normal-access path. A refresh starts only in a cycle where the normal path is not in the middle of a transaction (`norm_busy_i` low). While a refresh is queued or running, new normal commands are not granted. A normal request can therefore wait at most for the refreshes already in the queue. The queue depth matches the number of sweep segments in the tracker, so at most one full queue of requests arrives per sweep step. The queue drains well within one step. A push into a full queue is dropped and sets a sticky error flag, which stays low in correct operation.

Top module: `refresh_dispatch`

## Requirements
- R1: After reset the queue is empty, `ovf_o` is 0, and the command pins and `norm_gnt_o` simply follow the normal-path inputs (grant equals `norm_req_i`).
- R2: Refreshes are issued in the order the requests were pushed. Every pushed, accepted request produces exactly one refresh, and no refresh appears without a matching request.
- R3: A push while the queue holds `DEPTH` entries and no entry leaves in that cycle is dropped. `ovf_o` rises in the next cycle and stays 1 until reset.
- R4: A refresh strobe drives ras_n=0, cas_n=1, we_n=1 for exactly `RFC_CYC` consecutive cycles. The address bus carries the row and the bank select carries the bank, both stable for the whole strobe.
- R5: If `bank_open_i[bank]` is 1 when a request is started, the dispatcher first drives a one-cycle precharge (ras_n=0, cas_n=1, we_n=0, bank on the bank select). This is followed by exactly `RP_CYC` idle cycles (all three strobes high) and then the refresh strobe.
- R6: If the target bank is not open, no precharge is issued and the refresh strobe is the first command of that request.
- R7: After a strobe ends, RAS stays high for at least `RP_CYC`+1 cycles before the next refresh command.
- R8: While `norm_busy_i` is 1, no refresh starts, and the pins carry the normal-path inputs unchanged.
- R9: `norm_gnt_o` is 1 only when `norm_req_i` is 1, the queue is empty and no refresh is running.
- R10: With a full queue of requests to closed banks and the bus free, a waiting normal request is granted within `DEPTH`*(2+`RFC_CYC`+2*`RP_CYC`) cycles.
- R11: Whenever no refresh is running, the three strobes, address and bank select equal the normal-path inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Refresh request push strobe |
| req_bank_i | input | BANK_W | Bank of the row to refresh |
| req_row_i | input | ROW_W | Row to refresh |
| bank_open_i | input | NUM_BANKS | Per-bank open-page status |
| norm_busy_i | input | 1 | Normal path owns the command bus this cycle |
| norm_req_i | input | 1 | Normal path asks to start a command |
| norm_ras_n_i | input | 1 | Normal-path RAS (active low) |
| norm_cas_n_i | input | 1 | Normal-path CAS (active low) |
| norm_we_n_i | input | 1 | Normal-path WE (active low) |
| norm_addr_i | input | ROW_W | Normal-path address |
| norm_ba_i | input | BANK_W | Normal-path bank select |
| norm_gnt_o | output | 1 | Grant to start a normal command |
| ras_n_o | output | 1 | DRAM RAS pin (active low) |
| cas_n_o | output | 1 | DRAM CAS pin (active low) |
| we_n_o | output | 1 | DRAM WE pin (active low) |
| addr_o | output | ROW_W | DRAM address bus |
| ba_o | output | BANK_W | DRAM bank select |
| ovf_o | output | 1 | Sticky queue overflow error |

## Verification
Some internal faults show up on the pins within one refresh cycle:
- A wrong read pointer or entry width shows as a strobe carrying a row or bank that differs from the oldest expected request.
- A wrong down-counter load changes the length of the RAS-low window, or the gap after a precharge, by a cycle or more.

Other faults take longer to appear:
- Count or full-flag errors show as lost or extra strobes once the queue is filled to depth.
- An overflow flag set at the wrong boundary shows as early as the eighth push.
- Faults in the arbitration shows as strobes during a busy normal transaction, or as a grant while requests are still queued.

The scoreboard catches each of these cases as soon as the strobe ends or the grant is sampled.

// File: rtl/rfq_pkg.sv
package rfq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_PRE_WAIT,
    ST_STROBE,
    ST_RECOVER
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_NOP     = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_t CMD_PRE     = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_t CMD_ROW_REF = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/rfq_fifo.sv
module rfq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  // a pop in the same cycle frees the slot
  assign do_push = push_i && (!full || do_pop);
  assign data_o  = mem_q[rd_q];
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && !do_push) ovf_q <= 1'b1;
    end
  end

  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r3_full_push_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> ovf_q);
  a_r2_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rfq_seq.sv
module rfq_seq
  import rfq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int RFC_CYC   = 7,
  parameter int RP_CYC    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              empty_i,
  input  logic [BANK_W-1:0] head_bank_i,
  input  logic [ROW_W-1:0]  head_row_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic              norm_busy_i,
  output logic              pop_o,
  output logic              own_o,
  output cmd_t              cmd_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] ba_o
);
  localparam int MAXC  = (RFC_CYC > RP_CYC) ? RFC_CYC : RP_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(RFC_CYC - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(RP_CYC - 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic start, head_open;

  assign head_open = bank_open_i[head_bank_i];
  assign start     = !empty_i && !norm_busy_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pop_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        if (head_open) state_d = ST_PRE;
        else begin
          state_d = ST_STROBE;
          cnt_d   = RFC_LD;
        end
      end
      ST_PRE: begin
        state_d = ST_PRE_WAIT;
        cnt_d   = RP_LD;
      end
      ST_PRE_WAIT: begin
        if (cnt_q == '0) begin
          state_d = ST_STROBE;
          cnt_d   = RFC_LD;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_STROBE: begin
        if (cnt_q == '0) begin
          state_d = ST_RECOVER;
          cnt_d   = RP_LD;
          pop_o   = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_RECOVER: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    own_o  = (state_q != ST_IDLE);
    cmd_o  = CMD_NOP;
    addr_o = '0;
    ba_o   = '0;
    case (state_q)
      ST_PRE: begin
        cmd_o = CMD_PRE;
        ba_o  = head_bank_i;
      end
      ST_STROBE: begin
        cmd_o  = CMD_ROW_REF;
        addr_o = head_row_i;
        ba_o   = head_bank_i;
      end
      default: ;
    endcase
  end

  a_r8_start_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_IDLE && state_q != ST_IDLE) |-> (!$past(norm_busy_i) && !$past(empty_i)));
  a_r5_pre_then_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PRE |=> state_q == ST_PRE_WAIT);
  a_r4_head_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && $past(state_q) == ST_STROBE) |-> ($stable(head_row_i) && $stable(head_bank_i)));
  a_r7_pop_to_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> state_q == ST_RECOVER);
endmodule

// File: rtl/rfq_pinmux.sv
module rfq_pinmux
  import rfq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              own_i,
  input  logic              empty_i,
  input  cmd_t              ref_cmd_i,
  input  logic [ROW_W-1:0]  ref_addr_i,
  input  logic [BANK_W-1:0] ref_ba_i,
  input  logic              norm_req_i,
  input  cmd_t              norm_cmd_i,
  input  logic [ROW_W-1:0]  norm_addr_i,
  input  logic [BANK_W-1:0] norm_ba_i,
  output logic              gnt_o,
  output cmd_t              cmd_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] ba_o
);
  // queued refresh blocks new normal commands
  assign gnt_o  = norm_req_i && !own_i && empty_i;
  assign cmd_o  = own_i ? ref_cmd_i  : norm_cmd_i;
  assign addr_o = own_i ? ref_addr_i : norm_addr_i;
  assign ba_o   = own_i ? ref_ba_i   : norm_ba_i;

  a_r9_grant_owns_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> (cmd_o == norm_cmd_i && addr_o == norm_addr_i));
  a_r9_no_grant_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_i |-> !gnt_o);
endmodule

// File: rtl/refresh_dispatch.sv
module refresh_dispatch
  import rfq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int RFC_CYC   = 7,
  parameter int RP_CYC    = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [BANK_W-1:0]    req_bank_i,
  input  logic [ROW_W-1:0]     req_row_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic                 norm_busy_i,
  input  logic                 norm_req_i,
  input  logic                 norm_ras_n_i,
  input  logic                 norm_cas_n_i,
  input  logic                 norm_we_n_i,
  input  logic [ROW_W-1:0]     norm_addr_i,
  input  logic [BANK_W-1:0]    norm_ba_i,
  output logic                 norm_gnt_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic                 we_n_o,
  output logic [ROW_W-1:0]     addr_o,
  output logic [BANK_W-1:0]    ba_o,
  output logic                 ovf_o
);
  localparam int ENT_W = BANK_W + ROW_W;

  logic [ENT_W-1:0]  head;
  logic              empty, pop, own;
  cmd_t              ref_cmd, norm_cmd, pin_cmd;
  logic [ROW_W-1:0]  ref_addr;
  logic [BANK_W-1:0] ref_ba;

  rfq_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (req_valid_i),
    .data_i  ({req_bank_i, req_row_i}),
    .pop_i   (pop),
    .data_o  (head),
    .empty_o (empty),
    .ovf_o   (ovf_o)
  );

  rfq_seq #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .RFC_CYC(RFC_CYC), .RP_CYC(RP_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .empty_i     (empty),
    .head_bank_i (head[ENT_W-1:ROW_W]),
    .head_row_i  (head[ROW_W-1:0]),
    .bank_open_i (bank_open_i),
    .norm_busy_i (norm_busy_i),
    .pop_o       (pop),
    .own_o       (own),
    .cmd_o       (ref_cmd),
    .addr_o      (ref_addr),
    .ba_o        (ref_ba)
  );

  assign norm_cmd = '{ras_n: norm_ras_n_i, cas_n: norm_cas_n_i, we_n: norm_we_n_i};

  rfq_pinmux #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .own_i       (own),
    .empty_i     (empty),
    .ref_cmd_i   (ref_cmd),
    .ref_addr_i  (ref_addr),
    .ref_ba_i    (ref_ba),
    .norm_req_i  (norm_req_i),
    .norm_cmd_i  (norm_cmd),
    .norm_addr_i (norm_addr_i),
    .norm_ba_i   (norm_ba_i),
    .gnt_o       (norm_gnt_o),
    .cmd_o       (pin_cmd),
    .addr_o      (addr_o),
    .ba_o        (ba_o)
  );

  assign ras_n_o = pin_cmd.ras_n;
  assign cas_n_o = pin_cmd.cas_n;
  assign we_n_o  = pin_cmd.we_n;

  a_r8_busy_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (norm_busy_i && !own) |-> (ras_n_o == norm_ras_n_i && ba_o == norm_ba_i));
endmodule

// File: tb/refresh_dispatch_tb.sv
module refresh_dispatch_tb;
  localparam int DEPTH = 8, NB = 4, RW = 13, RFC = 7, RP = 2, BW = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, norm_busy = 0, norm_req = 0;
  logic [BW-1:0] req_bank = '0, norm_ba = '0;
  logic [RW-1:0] req_row = '0, norm_addr = '0;
  logic [NB-1:0] bank_open = '0;
  logic n_ras = 1, n_cas = 1, n_we = 1;
  logic gnt, ras_n, cas_n, we_n, ovf;
  logic [RW-1:0] addr;
  logic [BW-1:0] ba;

  always #5 clk = ~clk;

  refresh_dispatch #(.DEPTH(DEPTH), .NUM_BANKS(NB), .ROW_W(RW), .RFC_CYC(RFC), .RP_CYC(RP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_bank_i(req_bank),
    .req_row_i(req_row), .bank_open_i(bank_open), .norm_busy_i(norm_busy),
    .norm_req_i(norm_req), .norm_ras_n_i(n_ras), .norm_cas_n_i(n_cas), .norm_we_n_i(n_we),
    .norm_addr_i(norm_addr), .norm_ba_i(norm_ba), .norm_gnt_o(gnt), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .addr_o(addr), .ba_o(ba), .ovf_o(ovf));

  typedef struct { logic [BW-1:0] bank; logic [RW-1:0] row; bit pre; } ent_t;
  ent_t exp_q[$];
  int total = 0, bad = 0;
  bit mon_en = 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input logic [BW-1:0] b, input logic [RW-1:0] r, input bit acc);
    ent_t e;
    @(negedge clk);
    req_valid = 1; req_bank = b; req_row = r;
    if (acc) begin
      e.bank = b; e.row = r; e.pre = bank_open[b];
      exp_q.push_back(e);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (RP + 4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 drain", exp_q.size(), 0);
  endtask

  // scoreboard monitor
  int run = 0, hi_cnt = 0, gap = 0;
  bit saw_pre = 0, after_ref = 0, unstable = 0;
  logic [RW-1:0] f_addr;
  logic [BW-1:0] f_ba;
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (!ras_n && !we_n) begin
        if (after_ref) chk(hi_cnt >= RP + 1, "R7 gap before precharge", hi_cnt, RP + 1);
        after_ref = 0;
        chk(cas_n == 1, "R5 precharge cas_n", cas_n, 1);
        if (exp_q.size() == 0) chk(0, "R5 unexpected precharge", 1, 0);
        else begin
          chk(exp_q[0].pre, "R6 precharge on closed bank", 1, int'(exp_q[0].pre));
          chk(ba == exp_q[0].bank, "R5 precharge bank", ba, exp_q[0].bank);
        end
        saw_pre = 1; gap = 0;
      end else if (!ras_n) begin
        if (run == 0) begin
          if (after_ref) chk(hi_cnt >= RP + 1, "R7 gap between strobes", hi_cnt, RP + 1);
          after_ref = 0; unstable = 0;
          f_addr = addr; f_ba = ba;
          chk(cas_n == 1, "R4 cas_n high", cas_n, 1);
          if (exp_q.size() == 0) chk(0, "R2 unexpected refresh", addr, -1);
          else begin
            chk(addr == exp_q[0].row, "R2 row order", addr, exp_q[0].row);
            chk(ba == exp_q[0].bank, "R2 bank order", ba, exp_q[0].bank);
            if (exp_q[0].pre) chk(saw_pre && gap == RP, "R5 precharge gap", gap, RP);
            else chk(!saw_pre, "R6 no precharge", int'(saw_pre), 0);
          end
        end else if (addr != f_addr || ba != f_ba || !cas_n || !we_n) unstable = 1;
        run++;
      end else begin
        if (run > 0) begin
          chk(run == RFC, "R4 strobe length", run, RFC);
          chk(!unstable, "R4 strobe stable", int'(unstable), 0);
          if (exp_q.size() != 0) void'(exp_q.pop_front());
          run = 0; saw_pre = 0; after_ref = 1; hi_cnt = 0;
        end
        hi_cnt++; gap++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int waitc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(ras_n && cas_n && we_n, "R1 idle pins", {ras_n, cas_n, we_n}, 7);
    chk(ovf == 0, "R1 ovf clear", ovf, 0);
    chk(gnt == 0, "R1 no grant", gnt, 0);
    norm_req = 1; @(negedge clk);
    chk(gnt == 1, "R9 idle grant", gnt, 1);
    norm_req = 0;

    // R4/R6 closed bank
    push(2'd1, 13'h0123, 1);
    drain();
    // R5 open bank
    bank_open = 4'b0100;
    push(2'd2, 13'h1abc, 1);
    drain();
    // R2 mixed burst
    bank_open = 4'b1001;
    push(2'd3, 13'h0007, 1);
    push(2'd1, 13'h1fff, 1);
    push(2'd0, 13'h0400, 1);
    push(2'd2, 13'h0001, 1);
    push(2'd3, 13'h0aaa, 1);
    drain();
    bank_open = '0;

    // R8 busy holds refresh, pins pass through
    mon_en = 0;
    norm_busy = 1; n_ras = 0; n_cas = 0; n_we = 1; norm_addr = 13'h0055; norm_ba = 2'd3;
    push(2'd0, 13'h0333, 1);
    repeat (15) @(negedge clk);
    chk(ras_n == 0 && cas_n == 0 && addr == 13'h0055 && ba == 2'd3, "R8 busy pass", addr, 13'h55);
    norm_req = 1; @(negedge clk);
    chk(gnt == 0, "R9 grant blocked while queued", gnt, 0);
    norm_req = 0;
    n_ras = 1; n_cas = 1; norm_addr = '0; norm_ba = '0;
    @(negedge clk);
    mon_en = 1; norm_busy = 0;
    drain();

    // R10 hold-off bound
    norm_busy = 1;
    for (int i = 0; i < DEPTH; i++) push(BW'(i), RW'(16'h0100 + i), 1);
    norm_req = 1; norm_busy = 0;
    waitc = 0;
    @(negedge clk);
    chk(gnt == 0, "R9 no grant with full queue", gnt, 0);
    while (!gnt && waitc < 1000) begin @(negedge clk); waitc++; end
    chk(waitc <= DEPTH * (2 + RFC + 2 * RP), "R10 hold-off bound", waitc, DEPTH * (2 + RFC + 2 * RP));
    chk(exp_q.size() == 0, "R10 queue drained at grant", exp_q.size(), 0);
    norm_req = 0;
    drain();

    // R3 overflow
    norm_busy = 1;
    for (int i = 0; i < DEPTH; i++) push(BW'(3 - i % 4), RW'(16'h0800 + 3 * i), 1);
    chk(ovf == 0, "R3 no ovf at depth", ovf, 0);
    push(2'd1, 13'h1111, 0);
    chk(ovf == 1, "R3 ovf set", ovf, 1);
    norm_busy = 0;
    drain();
    repeat (30) @(negedge clk);
    chk(ovf == 1, "R3 ovf sticky", ovf, 1);
    chk(exp_q.size() == 0 && ras_n == 1, "R3 dropped entry not issued", ras_n, 1);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk(ovf == 0, "R1 ovf cleared by reset", ovf, 0);

    // R11 pass-through when idle
    mon_en = 0;
    n_ras = 0; n_cas = 1; n_we = 1; norm_addr = 13'h0f0f; norm_ba = 2'd2;
    @(negedge clk);
    chk(ras_n == 0 && cas_n == 1 && we_n == 1 && addr == 13'h0f0f && ba == 2'd2, "R11 pattern a", addr, 13'hf0f);
    n_ras = 1; n_cas = 0; n_we = 0; norm_addr = 13'h1234; norm_ba = 2'd1;
    @(negedge clk);
    chk(ras_n == 1 && cas_n == 0 && we_n == 0 && addr == 13'h1234 && ba == 2'd1, "R11 pattern b", addr, 13'h1234);
    n_ras = 1; n_cas = 1; n_we = 1; norm_addr = '0; norm_ba = '0;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && addr == 0, "R11 pattern c", addr, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule